// File: doc/BRIEF.md
# Memory-Card Host Normal Interrupt Status

This block keeps the normal interrupt status flags of a memory-card host controller. It watches activity levels and event pulses from the transfer engine and turns them into sticky status flags. Three flags come from falling edges of bus-activity levels. The block-gap flag also depends on a stop-at-gap request and on the transfer direction.

Each flag can only become set while its bit in a status-enable vector is 1. Software clears a flag by writing 1 to it through a small register write port. A second vector, the signal enable, selects which set flags drive the single registered interrupt line. The DMA engine, the card bus protocol and the data path are outside this block.

Top module: `sdh_irq_status`

## Requirements
- R1: A status bit can only become 1 while its `stat_en` bit is 1. An event that arrives while that enable is 0 is dropped and is not recorded later.
- R2: `irq` is a register. It is 1 in the cycle after a cycle in which some bit set in `status` also has its `sig_en` bit set. Otherwise it is 0.
- R3: A write (`wr_en`=1 with `wr_addr`=`STAT_ADDR`, default 0x30) clears every status bit whose `wr_data` bit is 1. Bits written 0 keep their value. Writes to any other address have no effect.
- R4: Bit 3 (DMA event) sets from a one-cycle `dma_evt` pulse. It sets for nothing else, including the end of a transfer.
- R5: Bit 2 (block gap) sets only while `stop_gap_req` is 1. During a read (`dir_read`=1) it sets on a falling edge of `dat_active`. During a write (`dir_read`=0) it sets on a falling edge of `wr_active`.
- R6: During a read, bit 1 (transfer done) sets on a falling edge of `rd_active`. This happens whether or not a gap stop was requested.
- R7: During a write, bit 1 sets on a falling edge of `wr_active`.
- R8: Bit 4 (write buffer ready) sets from a `wbuf_rdy` pulse.
- R9: When a set event and a write-1-to-clear hit the same bit in the same cycle, the bit ends up 1.
- R10: After reset, `status` and `irq` are 0. An activity level that is high when reset is released does not count as a falling edge.
- R11: Bit 0 and bits 5 and above of `status` always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | NSTAT | Write data; a 1 clears the matching flag |
| stat_en | input | NSTAT | Per-bit status enable |
| sig_en | input | NSTAT | Per-bit interrupt signal enable |
| stop_gap_req | input | 1 | Stop-at-block-gap request |
| dir_read | input | 1 | Transfer direction: 1 read, 0 write |
| dat_active | input | 1 | Data-line-active level |
| wr_active | input | 1 | Write-transfer-active level |
| rd_active | input | 1 | Read-transfer-active level |
| wbuf_rdy | input | 1 | Write-buffer-ready pulse |
| dma_evt | input | 1 | DMA boundary or descriptor-interrupt pulse |
| status | output | NSTAT | Status flags |
| irq | output | 1 | Registered interrupt |

## Verification
The levels are dropped in both directions, with the stop request both on and off. This shows that each falling edge lands on the right flag: the data-line edge counts only for reads, and the write-activity edge feeds both the gap and done flags on writes. Pulses that arrive with the enable off, writes to a wrong address, writes of 0, and a clear in the same cycle as a set each check one side of the set and clear rules. The signal-enable vector is switched while flags are held, which isolates the one-cycle interrupt lag.

// File: rtl/sdh_irq_pkg.sv
package sdh_irq_pkg;
   localparam int unsigned BIT_DONE = 1;
   localparam int unsigned BIT_GAP  = 2;
   localparam int unsigned BIT_DMA  = 3;
   localparam int unsigned BIT_WBUF = 4;
   localparam int unsigned MIN_NSTAT = 5;

   function automatic bit is_used(input int unsigned idx);
      return (idx == BIT_DONE) || (idx == BIT_GAP) ||
             (idx == BIT_DMA) || (idx == BIT_WBUF);
   endfunction
endpackage

// File: rtl/sdh_fall_det.sv
module sdh_fall_det #(
   parameter int unsigned W = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] lvl,
   output logic [W-1:0] fall
);
   logic [W-1:0] lvl_q;

   // Previous levels reset to 0 so reset release cannot look like a drop (R10)
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_q <= '0;
      else        lvl_q <= lvl;
   end

   assign fall = lvl_q & ~lvl;

   AST_NO_FALL_AFTER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (lvl == '0) |=> (fall == '0)); // R10
endmodule

// File: rtl/sdh_w1c_flag.sv
module sdh_w1c_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_ev,
   input  logic set_en,
   input  logic clr,
   output logic q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               q <= 1'b0;
      else if (set_ev && set_en) q <= 1'b1;   // set beats clear
      else if (clr)             q <= 1'b0;
   end

   AST_SET_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_en && !q) |=> !q); // R1
   AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !(set_ev && set_en)) |=> !q); // R3
   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (set_ev && set_en) |=> q); // R9
   AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (q && !clr) |=> q); // R3
endmodule

// File: rtl/sdh_irq_gate.sv
module sdh_irq_gate #(
   parameter int unsigned NSTAT   = 16,
   parameter bit          IRQ_REG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NSTAT-1:0] stat,
   input  logic [NSTAT-1:0] sig_en,
   output logic             irq
);
   logic hit;
   assign hit = |(stat & sig_en);

   if (IRQ_REG) begin : g_reg
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= hit;
      end
      assign irq = irq_q;

      AST_IRQ_NEEDS_SIGEN: assert property (@(posedge clk) disable iff (!rst_n)
         ((stat & sig_en) == '0) |=> !irq); // R2
      AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
         ((stat & sig_en) != '0) |=> irq); // R2
   end else begin : g_comb
      assign irq = hit;
   end
endmodule

// File: rtl/sdh_irq_status.sv
module sdh_irq_status
   import sdh_irq_pkg::*;
#(
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned NSTAT     = 16,
   parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h30,
   parameter bit          IRQ_REG   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [NSTAT-1:0]  wr_data,
   input  logic [NSTAT-1:0]  stat_en,
   input  logic [NSTAT-1:0]  sig_en,
   input  logic              stop_gap_req,
   input  logic              dir_read,
   input  logic              dat_active,
   input  logic              wr_active,
   input  logic              rd_active,
   input  logic              wbuf_rdy,
   input  logic              dma_evt,
   output logic [NSTAT-1:0]  status,
   output logic              irq
);
   localparam int unsigned NLVL = 3;
   localparam int unsigned L_DAT = 0;
   localparam int unsigned L_WR  = 1;
   localparam int unsigned L_RD  = 2;

   if (NSTAT < MIN_NSTAT) begin : g_bad_width
      $error("sdh_irq_status: NSTAT too small for the flag positions");
   end
   if (ADDR_W < 1) begin : g_bad_addr
      $error("sdh_irq_status: ADDR_W must be at least 1");
   end

   logic [NLVL-1:0]  lvl, fall;
   logic [NSTAT-1:0] ev_vec, clr_vec;
   logic             gap_ev, done_ev;

   assign lvl[L_DAT] = dat_active;
   assign lvl[L_WR]  = wr_active;
   assign lvl[L_RD]  = rd_active;

   sdh_fall_det #(.W(NLVL)) u_fall (
      .clk(clk), .rst_n(rst_n), .lvl(lvl), .fall(fall)
   );

   assign gap_ev  = stop_gap_req &
                    (dir_read ? fall[L_DAT] : fall[L_WR]);
   assign done_ev = dir_read ? fall[L_RD] : fall[L_WR];

   always_comb begin
      ev_vec           = '0;
      ev_vec[BIT_DONE] = done_ev;
      ev_vec[BIT_GAP]  = gap_ev;
      ev_vec[BIT_DMA]  = dma_evt;
      ev_vec[BIT_WBUF] = wbuf_rdy;
   end

   assign clr_vec = (wr_en && (wr_addr == STAT_ADDR)) ? wr_data : '0;

   for (genvar i = 0; i < NSTAT; i++) begin : g_flag
      localparam bit USED = is_used(i);
      sdh_w1c_flag u_flag (
         .clk   (clk),
         .rst_n (rst_n),
         .set_ev(USED ? ev_vec[i] : 1'b0),
         .set_en(stat_en[i]),
         .clr   (clr_vec[i]),
         .q     (status[i])
      );
   end

   sdh_irq_gate #(.NSTAT(NSTAT), .IRQ_REG(IRQ_REG)) u_gate (
      .clk(clk), .rst_n(rst_n), .stat(status), .sig_en(sig_en), .irq(irq)
   );

   AST_GAP_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (!stop_gap_req && !status[BIT_GAP]) |=> !status[BIT_GAP]); // R5
   AST_DMA_ONLY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      (!dma_evt && !status[BIT_DMA]) |=> !status[BIT_DMA]); // R4
   AST_BIT0_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !status[0]); // R11
endmodule

// File: tb/test_sdh_irq_status.sv
`timescale 1ns/1ps
module test_sdh_irq_status;
   localparam int NS = 16;

   logic clk = 0, rst_n = 0;
   logic wr_en = 0;
   logic [7:0] wr_addr = 0;
   logic [NS-1:0] wr_data = 0, stat_en = 0, sig_en = 0;
   logic stop_gap_req = 0, dir_read = 0, dat_active = 0, wr_active = 0;
   logic rd_active = 0, wbuf_rdy = 0, dma_evt = 0;
   logic [NS-1:0] status;
   logic irq;

   int checks = 0, failures = 0;
   bit done = 0;

   always #5 clk = ~clk;

   sdh_irq_status i_sdh_irq_status (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .stat_en(stat_en), .sig_en(sig_en),
      .stop_gap_req(stop_gap_req), .dir_read(dir_read),
      .dat_active(dat_active), .wr_active(wr_active), .rd_active(rd_active),
      .wbuf_rdy(wbuf_rdy), .dma_evt(dma_evt), .status(status), .irq(irq)
   );

   // behavioural reference model
   int m_stat = 0;
   int m_irq = 0;
   int prev_lv[$] = '{0, 0, 0};

   always @(posedge clk) begin
      if (!rst_n) begin
         m_stat = 0; m_irq = 0; prev_lv = '{0, 0, 0};
      end else begin
         int fdat, fwr, frd, setm, clrm;
         fdat = (prev_lv[0] == 1 && dat_active == 0);
         fwr  = (prev_lv[1] == 1 && wr_active == 0);
         frd  = (prev_lv[2] == 1 && rd_active == 0);
         m_irq = ((m_stat & int'(sig_en)) != 0);
         setm = 0;
         if (dir_read ? frd : fwr) setm += 2;
         if (stop_gap_req && (dir_read ? fdat : fwr)) setm += 4;
         if (dma_evt) setm += 8;
         if (wbuf_rdy) setm += 16;
         setm = setm & int'(stat_en);
         clrm = (wr_en && wr_addr == 8'h30) ? int'(wr_data) : 0;
         m_stat = (m_stat & ~clrm) | setm;
         prev_lv = '{int'(dat_active), int'(wr_active), int'(rd_active)};
      end
   end

   function automatic string req_of(int b);
      case (b)
         1: return "R6/R7";
         2: return "R5";
         3: return "R4";
         4: return "R8";
         default: return "R11";
      endcase
   endfunction

   always @(negedge clk) begin
      if (rst_n && !done) begin
         checks++;
         if (int'(status) != m_stat || int'(irq) != m_irq) begin
            failures++;
            for (int b = 0; b < NS; b++)
               if (status[b] != m_stat[b])
                  $display("FAIL %s model bit %0d: actual=%0h expected=%0h",
                           req_of(b), b, status, m_stat);
            if (int'(irq) != m_irq)
               $display("FAIL R2 model irq: actual=%0d expected=%0d", irq, m_irq);
         end
      end
   end

   task automatic check(bit ok, string tag, int act, int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk); #1;
   endtask

   task automatic chk_stat(string tag, int exp);
      check(int'(status) == exp, tag, int'(status), exp);
   endtask

   task automatic wclr(int d, logic [7:0] a = 8'h30);
      wr_en = 1; wr_addr = a; wr_data = NS'(d); tick(); wr_en = 0;
   endtask

   initial begin
      fork
         begin
            repeat (5000) @(posedge clk);
            failures++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
         end
      join_none

      // R10: levels high through reset, released high
      dat_active = 1; wr_active = 1; rd_active = 1;
      repeat (3) tick();
      rst_n = 1; tick();
      chk_stat("R10 reset status", 0);
      check(irq == 0, "R10 reset irq", irq, 0);
      dat_active = 0; wr_active = 0; rd_active = 0; tick(); tick();

      stat_en = 16'h001E; sig_en = 0; dir_read = 1;
      // R4 DMA pulse
      dma_evt = 1; tick(); dma_evt = 0;
      chk_stat("R4 dma pulse sets bit3", 8);
      // R3 wrong address does nothing
      wclr(16'hFFFF, 8'h31);
      chk_stat("R3 other address ignored", 8);
      // R3 write 0 keeps
      wclr(16'h0010);
      chk_stat("R3 write-0 keeps bit3", 8);
      check(irq == 0, "R2 no sig_en no irq", irq, 0);
      sig_en = 16'h0008; tick();
      check(irq == 1, "R2 irq with sig_en", irq, 1);
      wclr(16'h0008);
      chk_stat("R3 write-1 clears", 0);
      tick();
      check(irq == 0, "R2 irq drops after clear", irq, 0);

      // R1 disabled event dropped
      stat_en = 16'h000E; wbuf_rdy = 1; tick(); wbuf_rdy = 0;
      chk_stat("R1 disabled event dropped", 0);
      stat_en = 16'hFFFF; tick();
      chk_stat("R1 not recorded later", 0);
      wbuf_rdy = 1; tick(); wbuf_rdy = 0;
      chk_stat("R8 wbuf sets bit4", 16);
      wclr(16'h0010);

      // read, no gap request
      dat_active = 1; rd_active = 1; tick();
      dat_active = 0; tick();
      chk_stat("R5 no gap without request", 0);
      rd_active = 0; tick();
      chk_stat("R6 read done, R4 no dma, R11", 2);
      wclr(16'h0002);

      // read with gap request
      dat_active = 1; rd_active = 1; tick();
      stop_gap_req = 1; dat_active = 0; tick();
      chk_stat("R5 read gap on data-line drop", 4);
      rd_active = 0; tick();
      chk_stat("R6 done after gap stop", 6);
      wclr(16'h0006);
      chk_stat("R3 cleared both", 0);

      // write direction
      dir_read = 0; wr_active = 1; dat_active = 1; tick();
      dat_active = 0; tick();
      chk_stat("R5 data-line drop ignored on write", 0);
      wr_active = 0; tick();
      chk_stat("R7 write done and R5 gap", 6);
      wclr(16'h0006);
      stop_gap_req = 0; wr_active = 1; tick(); wr_active = 0; tick();
      chk_stat("R7 write done, R5 no gap", 2);
      wclr(16'h0002);

      // R9 set wins over clear
      wbuf_rdy = 1; tick();
      wr_en = 1; wr_addr = 8'h30; wr_data = 16'h0010; tick();
      wr_en = 0; wbuf_rdy = 0;
      chk_stat("R9 set wins", 16);
      wclr(16'h0010);
      chk_stat("R9 later clear", 0);
      repeat (4) tick();

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule